// File: doc/BRIEF.md
# Selectable Prescaler and Up-Counter with Retrigger Alignment

This block divides the raw clock into a clock-enable tick and counts those ticks in a 16-bit up-counter. A 3-bit select picks one of eight division factors. The factors rise in steps that are not uniform: 1, 2, 4, 8, 16, 64, 256 and 1024. The counter runs from its current value up to a programmable top value, wraps to zero and then raises an overflow pulse for one clock.

A retrigger input loads the counter with a reload value. A reload value of zero clears the counter. A 2-bit alignment select sets when the load happens. It can happen on the next raw clock edge. It can wait for the next prescaled tick, in which case it is held pending. Or it can happen on the next raw clock edge and also restart the prescaler phase. The block halts in standby unless it is told to keep running. An optional lock-update flag marks every overflow and every retrigger.

Every pin is a plain level or pulse control sampled on each rising clock edge. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure. The outputs are valid in every cycle.

Top module: `presc_counter`

## Requirements
- R1: Select codes 0..7 give a tick once every 1, 2, 4, 8, 16, 64, 256 and 1024 running clocks respectively. The tick output is high during the last clock of each period.
- R2: On each tick the counter adds one. When the counter already equals the top value, the tick sets it to 0 instead, and the overflow output is high for the following single clock.
- R3: With alignment code 0, or the reserved code 3, a retrigger sampled while the block runs loads the reload value at that clock edge. The prescaler phase is unaffected.
- R4: With alignment code 1, a retrigger is held pending and the load happens at the next tick. Any number of retriggers before that tick cause exactly one load.
- R5: Alignment code 2 loads the counter at the same edge as code 0 does. It also restarts the prescaler, so the next tick comes a full period later.
- R6: When standby is high and run-in-standby is low, the counter and the prescaler phase hold, and no tick is produced.
- R7: When run-in-standby is high, standby has no effect on counting or ticks.
- R8: When enable is low, the prescaler phase returns to zero, the counter holds its value, no tick is produced and retriggers are discarded.
- R9: When auto-lock is high, every overflow and every retrigger load sets the lock flag one clock later. The lock-clear input clears the flag, except when a set happens in the same clock, in which case the set wins.
- R10: When a retrigger load and a wrap fall on the same tick, the load wins and no overflow pulse is produced.
- R11: After reset the count is 0, overflow is low, the lock flag is low and the prescaler phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| standby_i | input | 1 | System standby indication |
| run_stby_i | input | 1 | Keep running while in standby |
| div_sel_i | input | 3 | Division select code |
| align_sel_i | input | 2 | Retrigger alignment code |
| retrig_i | input | 1 | Retrigger request, sampled each clock |
| reload_i | input | 16 | Value loaded by a retrigger |
| top_i | input | 16 | Wrap limit of the counter |
| auto_lock_i | input | 1 | Set lock flag on overflow or retrigger |
| lock_clr_i | input | 1 | Clear the lock flag |
| count_o | output | 16 | Counter value |
| tick_o | output | 1 | Prescaled clock-enable tick |
| ovf_o | output | 1 | One-clock wrap pulse |
| lock_upd_o | output | 1 | Lock-update flag |

## Verification
The riskiest overlap is a retrigger load landing on the tick at which the counter sits at its top value. Wrap and load then compete for the same register, and the overflow pulse must be suppressed. The bench provokes this in two ways. It holds a pending retrigger in tick-aligned mode across a wrap with a small top value. It also pulses a raw-aligned retrigger with divide-by-one exactly when the count equals the top value. A cycle-level model judges both cases by expecting the reload value and no overflow. The same runs also place a lock-clear on the clock where auto-lock sets the flag.

// File: rtl/presc_pkg.sv
package presc_pkg;

  // width of the prescaler phase register, enough for the largest factor
  localparam int unsigned PHASE_W = 10;

  typedef enum logic [1:0] {
    ALIGN_RAW   = 2'd0,
    ALIGN_TICK  = 2'd1,
    ALIGN_RESET = 2'd2,
    ALIGN_RSVD  = 2'd3
  } align_e;

  // log2 of the division factor for each select code
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    div_shift = 4'd0;
      3'd1:    div_shift = 4'd1;
      3'd2:    div_shift = 4'd2;
      3'd3:    div_shift = 4'd3;
      3'd4:    div_shift = 4'd4;
      3'd5:    div_shift = 4'd6;
      3'd6:    div_shift = 4'd8;
      default: div_shift = 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/presc_phase.sv
module presc_phase
  import presc_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             phase_rst_i,
  output logic             tick_o
);

  localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

  logic [PHASE_W-1:0] phase_q, phase_d, term;

  // terminal count = factor - 1; for factor 1024 the shift wraps to 0 and
  // the subtraction yields all ones, which is the wanted limit
  always_comb begin
    term = (ONE << div_shift(sel_i[2:0])) - ONE;
  end

  // >= keeps the divider live when the select shrinks mid-period
  assign tick_o = run_i && (phase_q >= term);

  always_comb begin
    if (!en_i)            phase_d = '0;
    else if (phase_rst_i) phase_d = '0;
    else if (!run_i)      phase_d = phase_q;
    else if (tick_o)      phase_d = '0;
    else                  phase_d = phase_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  AST_PHASE_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> phase_q == '0); // R8
  AST_PHASE_HELD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !run_i && !phase_rst_i) |=> $stable(phase_q)); // R6
  AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o); // R6

endmodule

// File: rtl/presc_retrig.sv
module presc_retrig
  import presc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       retrig_i,
  input  logic [1:0] align_i,
  output logic       load_o,
  output logic       phase_rst_o
);

  align_e mode;
  logic   pend_q, pend_d;

  assign mode = align_e'(align_i);

  always_comb begin
    case (mode)
      ALIGN_TICK:  load_o = tick_i && (pend_q || retrig_i);
      default:     load_o = run_i && retrig_i;
    endcase
    phase_rst_o = (mode == ALIGN_RESET) && load_o;
  end

  always_comb begin
    if (!en_i || mode != ALIGN_TICK) pend_d = 1'b0;
    else if (load_o)                 pend_d = 1'b0;
    else                             pend_d = pend_q || retrig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !pend_q); // R4
  AST_TICK_MODE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ALIGN_TICK && load_o) |-> tick_i); // R4

endmodule

// File: rtl/presc_count.sv
module presc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top, wrap_d;

  assign at_top = (cnt_q == top_i);

  always_comb begin
    wrap_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;           // load wins over a wrap on the same tick
    end else if (step_i) begin
      if (at_top) begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_o <= wrap_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q)); // R8
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> cnt_q == '0); // R2
  AST_LOAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !wrap_o); // R10

endmodule

// File: rtl/presc_counter.sv
module presc_counter
  import presc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             standby_i,
  input  logic             run_stby_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [1:0]       align_sel_i,
  input  logic             retrig_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             auto_lock_i,
  input  logic             lock_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o,
  output logic             ovf_o,
  output logic             lock_upd_o
);

  logic run, tick, load, phase_rst, wrap, lock_set;

  assign run = en_i && !(standby_i && !run_stby_i);

  presc_phase #(.SEL_W(SEL_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .run_i       (run),
    .sel_i       (div_sel_i),
    .phase_rst_i (phase_rst),
    .tick_o      (tick)
  );

  presc_retrig u_retrig (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .run_i       (run),
    .tick_i      (tick),
    .retrig_i    (retrig_i),
    .align_i     (align_sel_i),
    .load_o      (load),
    .phase_rst_o (phase_rst)
  );

  presc_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (tick),
    .load_i     (load),
    .load_val_i (reload_i),
    .top_i      (top_i),
    .cnt_o      (count_o),
    .wrap_o     (wrap)
  );

  // a wrap is known one clock before ovf_o shows it, so the flag and the
  // pulse rise together
  assign lock_set = auto_lock_i && (load || (tick && count_o == top_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_upd_o <= 1'b0;
    else if (lock_set)   lock_upd_o <= 1'b1;
    else if (lock_clr_i) lock_upd_o <= 1'b0;
  end

  assign tick_o = tick;
  assign ovf_o  = wrap;

  AST_LOCK_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && $past(auto_lock_i)) |-> lock_upd_o); // R9
  AST_OVF_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(run)); // R6

endmodule

// File: tb/tb_presc_counter.sv
`timescale 1ns/100ps
module tb_presc_counter;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 0, stby = 0, rstby = 0, retrig = 0, al = 0, lclr = 0;
  logic [2:0]    sel = 0;
  logic [1:0]    align = 0;
  logic [CW-1:0] reload = 0, top = 0;
  logic [CW-1:0] count;
  logic          tick, ovf, lock;

  always #2.5 clk = ~clk;   // 200 MHz

  presc_counter dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .standby_i(stby), .run_stby_i(rstby),
    .div_sel_i(sel), .align_sel_i(align), .retrig_i(retrig), .reload_i(reload),
    .top_i(top), .auto_lock_i(al), .lock_clr_i(lclr),
    .count_o(count), .tick_o(tick), .ovf_o(ovf), .lock_upd_o(lock)
  );

  typedef struct packed { logic [CW-1:0] cnt; logic ovf; logic lock; } exp_t;
  exp_t q[$];

  int    compared = 0, mismatched = 0;
  string tag = "R11";
  bit    done = 0;

  // behaviour model, derived from the requirement list
  int            m_ph = 0;
  bit            m_pend = 0, m_ovf = 0, m_lock = 0;
  logic [CW-1:0] m_cnt = 0;

  function automatic int factor(input logic [2:0] s);
    case (s)
      3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
      3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic bit m_run();
    return en && !(stby && !rstby);
  endfunction

  function automatic bit m_tick();
    return m_run() && (m_ph >= factor(sel) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_cnt = 0; m_ovf = 0; m_lock = 0;
    end else begin
      bit t, ld, wr;
      t  = m_tick();
      ld = (align == 2'd1) ? (t && (m_pend || retrig)) : (m_run() && retrig);
      wr = t && !ld && (m_cnt == top);
      if (!en)                       m_ph = 0;
      else if (align == 2'd2 && ld)  m_ph = 0;
      else if (!m_run())             m_ph = m_ph;
      else if (t)                    m_ph = 0;
      else                           m_ph = m_ph + 1;
      if (!en || align != 2'd1 || ld) m_pend = 0;
      else                            m_pend = m_pend || retrig;
      if (al && (ld || wr)) m_lock = 1;
      else if (lclr)        m_lock = 0;
      if (ld)      m_cnt = reload;
      else if (wr) m_cnt = 0;
      else if (t)  m_cnt = m_cnt + 1;
      m_ovf = wr;
    end
    q.push_back('{cnt: m_cnt, ovf: m_ovf, lock: m_lock});
  end

  // monitor: compares away from the clock edge
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (count !== e.cnt || ovf !== e.ovf || lock !== e.lock) begin
        mismatched++;
        $display("FAIL %s @%0t: cnt/ovf/lock act=%0d/%0b/%0b exp=%0d/%0b/%0b",
                 tag, $time, count, ovf, lock, e.cnt, e.ovf, e.lock);
      end
      compared++;
      if (tick !== m_tick()) begin
        mismatched++;
        $display("FAIL %s @%0t: tick act=%0b exp=%0b", tag, $time, tick, m_tick());
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_retrig();
    retrig = 1; cyc(1); retrig = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    tag = "R11"; cyc(3);

    tag = "R1 R2 div4"; en = 1; sel = 3'd2; top = 16'd5; cyc(40);
    tag = "R1 R2 div1"; sel = 3'd0; top = 16'd3; cyc(20);
    tag = "R1 div64";  sel = 3'd5; top = 16'd1; cyc(200);
    tag = "R1 R2 div1024"; sel = 3'd7; top = 16'd0; cyc(2100);
    tag = "R1 div2 div8 div16 div256"; top = 16'd40;
    sel = 3'd1; cyc(20); sel = 3'd3; cyc(40); sel = 3'd4; cyc(60); sel = 3'd6; cyc(600);

    tag = "R3 raw align"; sel = 3'd2; top = 16'd50; align = 2'd0; reload = 16'd7;
    cyc(5); pulse_retrig(); cyc(2); pulse_retrig(); cyc(6);
    tag = "R3 reserved code"; align = 2'd3; reload = 16'd0; cyc(3); pulse_retrig(); cyc(8);

    tag = "R4 tick align"; align = 2'd1; sel = 3'd3; reload = 16'd100; cyc(3);
    pulse_retrig(); cyc(1); pulse_retrig(); cyc(20);
    retrig = 1; cyc(12); retrig = 0; cyc(10);

    tag = "R5 phase restart"; align = 2'd2; reload = 16'd20; cyc(5);
    pulse_retrig(); cyc(3); pulse_retrig(); cyc(20);

    tag = "R6 standby halt"; align = 2'd0; rstby = 0; stby = 1; cyc(20);
    pulse_retrig(); cyc(5);
    tag = "R7 run in standby"; rstby = 1; cyc(30); stby = 0; rstby = 0; cyc(5);

    tag = "R8 disabled"; en = 0; cyc(10); pulse_retrig(); cyc(5);
    align = 2'd1; pulse_retrig(); cyc(3); en = 1; cyc(20);

    tag = "R9 auto lock"; al = 1; sel = 3'd0; top = 16'd4; align = 2'd0; cyc(8);
    lclr = 1; cyc(1); lclr = 0; cyc(2); al = 0; lclr = 1; cyc(2); lclr = 0;
    al = 1; pulse_retrig(); al = 0; cyc(3); lclr = 1; cyc(1); lclr = 0; cyc(3);

    tag = "R10 load vs wrap raw"; al = 1; reload = 16'd9; top = 16'd2;
    while (count != top) cyc(1);
    lclr = 1; pulse_retrig(); lclr = 0; cyc(6);
    tag = "R10 load vs wrap pending"; align = 2'd1; sel = 3'd1; top = 16'd1;
    reload = 16'd3; cyc(1); retrig = 1; cyc(8); retrig = 0; cyc(10);

    done = 1;
    cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule